// File: doc/BRIEF.md
# Two-wire configuration register target

This block is a target on a two-wire (I2C) serial bus. It gives a bus host read and write access to a file of twenty byte-wide configuration registers. Every register is presented in parallel on an output bus. A one-cycle write strobe reports each accepted write, with its index and data, so that neighbouring logic can react to the change. The block samples SCL and SDA on its own system clock. It only ever pulls SDA low, through an open-drain enable output, and it never stretches the clock.

Each write transaction carries a command byte, and this byte selects the transfer style:

- **Block style.** A command byte of 0x00 selects block style. A block write sends a byte count and then the data, which fills the registers upward from index 0. A block read returns the register count first, and then every register in ascending order.
- **Single-register style.** Any other command byte c selects single-register style, and the register addressed is c−1.

Indices 0 to 3 are placeholders: they read as zero and ignore writes. The two highest indices hold fixed identification values.

The controller is one state machine with these states:

- IDLE: waits for a START.
- GET_ADDR and ACK_ADDR: receive and acknowledge the device address.
- GET_CMD and ACK_CMD: receive and acknowledge the command byte.
- GET_CNT and ACK_CNT: receive and acknowledge the block count.
- GET_DATA and ACK_DATA: receive and acknowledge data bytes.
- PUT_BYTE: shifts a byte out to the host.
- HOST_ACK: samples the host's acknowledge.
- WAIT_STOP: the machine stays silent here until the next START or STOP.

The transitions are:

- START from any state → GET_ADDR.
- STOP from any state → IDLE.
- GET_x → ACK_x after the eighth bit. A mismatched address instead goes to WAIT_STOP.
- ACK_ADDR → GET_CMD for a write, or → PUT_BYTE for a read.
- ACK_CMD → GET_CNT for command 0x00, otherwise → GET_DATA.
- ACK_CNT → GET_DATA.
- ACK_DATA → GET_DATA.
- PUT_BYTE → HOST_ACK after the eighth bit.
- HOST_ACK → PUT_BYTE on an acknowledge, or → WAIT_STOP on a not-acknowledge.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x69 (bus byte 0xD2 for write, 0xD3 for read) by driving SDA low in the ninth clock. Any other address gets no acknowledge, and the rest of that transaction changes no register.
- R2: After reset the register outputs hold these values:
  - index 5, 6 and 7: 0xFF
  - index 8: 0xCE
  - index 10: 0x08
  - index 11: 0xAB
  - index 12: 0x2F
  - index 13: 0x1F
  - index 14: 0x4C
  - index 15: 0xA7
  - index 16: 0x1C
  - index 17: 0x24
  - index 4, index 9 and indices 0 to 3: 0x00
- R3: A write with command byte c from 1 to 255 stores the first data byte into register c−1. The target acknowledges further data bytes in the same transaction but stores none of them.
- R4: In a read that follows command c ≠ 0 (after a repeated START), the first byte returned is register c−1. Each byte the host acknowledges is followed by the next higher register. Indices of 20 and above read 0xFF.
- R5: A write with command 0x00 takes the next byte as a count n. The following bytes go to registers 0, 1, 2, … in order. Bytes beyond the n-th are acknowledged and discarded.
- R6: A read after command 0x00 returns the value 20 first, then registers 0 to 19 in ascending order, then 0xFF for any further byte.
- R7: Registers 0 to 3 always read 0x00 and ignore writes.
- R8: Register 18 reads 0x77 and register 19 reads 0x11, and writes to them are ignored.
- R9: Each stored write raises wr_stb for exactly one clock, carrying the register index on wr_idx and the stored byte on wr_data. Only indices 4 to 17 produce a strobe.
- R10: After the host answers a read byte with not-acknowledge, the target keeps SDA released until the next START.
- R11: A STOP in the middle of a byte abandons it and returns the target to IDLE. A START in the middle of a byte abandons it and restarts address reception.
- R12: The target changes its SDA drive only while SCL is low, and it never pulls SDA low while the host is sending a 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_flat | output | 160 | All registers, index i at bits [8i+7:8i] |
| wr_stb | output | 1 | One-cycle pulse per stored write |
| wr_idx | output | 8 | Index of the register just written |
| wr_data | output | 8 | Byte just written |

## Verification
Directed transactions cover each transfer style separately:

- single-register writes into writable, placeholder and identification slots, each followed by a read-back;
- sequential reads that are acknowledged past the first byte;
- block writes that send more bytes than their count;
- a block read that overruns the end of the file.

These separate the command-minus-one index mapping from the block start-at-zero mapping. They also show a write that was accepted apart from one that was silently dropped.

Seeded random mixes of the three operations then use random indices (including ones past the end), random data and random counts from 0 to 22. The model and the outputs therefore diverge if the count limit, the index offset or the writable range is wrong.

Finally, a foreign address, a not-acknowledge followed by extra clocks, and STOP or START in the middle of a byte test whether the target stays off the bus when it must.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GET_ADDR,
        S_ACK_ADDR,
        S_GET_CMD,
        S_ACK_CMD,
        S_GET_CNT,
        S_ACK_CNT,
        S_GET_DATA,
        S_ACK_DATA,
        S_PUT_BYTE,
        S_HOST_ACK,
        S_WAIT_STOP
    } slv_state_e;

    // Power-up contents of the writable slots; everything else starts at zero.
    function automatic logic [7:0] cfg_reset_val(input int idx);
        case (idx)
            5, 6, 7: return 8'hFF;
            8:       return 8'hCE;
            10:      return 8'h08;
            11:      return 8'hAB;
            12:      return 8'h2F;
            13:      return 8'h1F;
            14:      return 8'h4C;
            15:      return 8'hA7;
            16:      return 8'h1C;
            17:      return 8'h24;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] sat_inc(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC + 1;

    logic [DEPTH-1:0] scl_sh, sda_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[DEPTH-2:0], scl_pin};
            sda_sh <= {sda_sh[DEPTH-2:0], sda_pin};
        end
    end

    assign sda_hi    = sda_sh[SYNC-1];
    assign scl_rise  =  scl_sh[SYNC-1] & ~scl_sh[SYNC];
    assign scl_fall  = ~scl_sh[SYNC-1] &  scl_sh[SYNC];
    assign start_det =  scl_sh[SYNC-1] &  scl_sh[SYNC] & ~sda_sh[SYNC-1] &  sda_sh[SYNC];
    assign stop_det  =  scl_sh[SYNC-1] &  scl_sh[SYNC] &  sda_sh[SYNC-1] & ~sda_sh[SYNC];
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
    import i2c_cfg_pkg::*;
#(
    parameter int          NREG    = 20,
    parameter int          RSVD    = 4,
    parameter logic [7:0]  ID_MAIN = 8'h77,
    parameter logic [7:0]  ID_SUB  = 8'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_idx,
    output logic [7:0]         rd_data,
    output logic [NREG*8-1:0]  regs_flat,
    output logic               upd_stb,
    output logic [7:0]         upd_idx,
    output logic [7:0]         upd_data
);
    localparam int LAST_RW = NREG - 3;

    logic wr_ok;
    assign wr_ok = wr_en && (wr_idx >= 8'(RSVD)) && (wr_idx <= 8'(LAST_RW));

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g >= RSVD && g <= LAST_RW) begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= cfg_reset_val(g);
                else if (wr_ok && wr_idx == 8'(g))
                    q <= wr_data;
            end
            assign regs_flat[g*8 +: 8] = q;
        end else if (g == NREG - 2) begin : g_id_main
            assign regs_flat[g*8 +: 8] = ID_MAIN;
        end else if (g == NREG - 1) begin : g_id_sub
            assign regs_flat[g*8 +: 8] = ID_SUB;
        end else begin : g_rsvd
            assign regs_flat[g*8 +: 8] = 8'h00;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == 8'(i)) rd_data = regs_flat[i*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_stb  <= 1'b0;
            upd_idx  <= 8'h00;
            upd_data <= 8'h00;
        end else begin
            upd_stb <= wr_ok;
            if (wr_ok) begin
                upd_idx  <= wr_idx;
                upd_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int          NREG     = 20,
    parameter int          RSVD     = 4,
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    parameter logic [7:0]  ID_MAIN  = 8'h77,
    parameter logic [7:0]  ID_SUB   = 8'h11,
    parameter int          SYNC     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [NREG*8-1:0]  regs_flat,
    output logic               wr_stb,
    output logic [7:0]         wr_idx,
    output logic [7:0]         wr_data
);
    slv_state_e state;
    logic       sda_hi, scl_rise, scl_fall, start_det, stop_det;
    logic [2:0] bitcnt;
    logic       byte_full, is_read, blk, host_nack;
    logic [7:0] shreg, tx_sh, ptr, wcnt, cnt_lim;
    logic       wr_en;
    logic [7:0] rd_data;
    logic       in_quiet;

    i2c_bus_sense #(.SYNC(SYNC)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_in), .sda_pin(sda_in),
        .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_cfg_regs #(.NREG(NREG), .RSVD(RSVD), .ID_MAIN(ID_MAIN), .ID_SUB(ID_SUB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(shreg),
        .rd_idx(ptr), .rd_data(rd_data), .regs_flat(regs_flat),
        .upd_stb(wr_stb), .upd_idx(wr_idx), .upd_data(wr_data)
    );

    // State register and datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            bitcnt    <= 3'd0;
            byte_full <= 1'b0;
            is_read   <= 1'b0;
            blk       <= 1'b0;
            host_nack <= 1'b0;
            shreg     <= 8'h00;
            tx_sh     <= 8'hFF;
            ptr       <= 8'h00;
            wcnt      <= 8'h00;
            cnt_lim   <= 8'h00;
        end else if (stop_det) begin
            state     <= S_IDLE;
            bitcnt    <= 3'd0;
            byte_full <= 1'b0;
        end else if (start_det) begin
            state     <= S_GET_ADDR;
            bitcnt    <= 3'd0;
            byte_full <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_WAIT_STOP: ;
                S_GET_ADDR, S_GET_CMD, S_GET_CNT, S_GET_DATA: begin
                    if (scl_rise && !byte_full) begin
                        shreg  <= {shreg[6:0], sda_hi};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) byte_full <= 1'b1;
                    end else if (scl_fall && byte_full) begin
                        byte_full <= 1'b0;
                        bitcnt    <= 3'd0;
                        if (state == S_GET_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                state   <= S_ACK_ADDR;
                                is_read <= shreg[0];
                            end else begin
                                state <= S_WAIT_STOP;
                            end
                        end else if (state == S_GET_CMD) begin
                            state   <= S_ACK_CMD;
                            blk     <= (shreg == 8'h00);
                            ptr     <= (shreg == 8'h00) ? 8'h00 : shreg - 8'd1;
                            cnt_lim <= 8'd1;
                            wcnt    <= 8'h00;
                        end else if (state == S_GET_CNT) begin
                            state   <= S_ACK_CNT;
                            cnt_lim <= shreg;
                        end else begin
                            state <= S_ACK_DATA;
                            wcnt  <= sat_inc(wcnt);
                            ptr   <= sat_inc(ptr);
                        end
                    end
                end
                S_ACK_ADDR: if (scl_fall) begin
                    if (is_read) begin
                        state <= S_PUT_BYTE;
                        tx_sh <= blk ? 8'(NREG) : rd_data;
                        if (!blk) ptr <= sat_inc(ptr);
                    end else begin
                        state <= S_GET_CMD;
                    end
                end
                S_ACK_CMD:  if (scl_fall) state <= blk ? S_GET_CNT : S_GET_DATA;
                S_ACK_CNT:  if (scl_fall) state <= S_GET_DATA;
                S_ACK_DATA: if (scl_fall) state <= S_GET_DATA;
                S_PUT_BYTE: if (scl_fall) begin
                    if (bitcnt == 3'd7) begin
                        state  <= S_HOST_ACK;
                        bitcnt <= 3'd0;
                    end else begin
                        tx_sh  <= {tx_sh[6:0], 1'b1};
                        bitcnt <= bitcnt + 3'd1;
                    end
                end
                S_HOST_ACK: begin
                    if (scl_rise) host_nack <= sda_hi;
                    else if (scl_fall) begin
                        if (host_nack) begin
                            state <= S_WAIT_STOP;
                        end else begin
                            state <= S_PUT_BYTE;
                            tx_sh <= rd_data;
                            ptr   <= sat_inc(ptr);
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        sda_oe   = 1'b0;
        wr_en    = 1'b0;
        in_quiet = (state == S_IDLE) || (state == S_WAIT_STOP);
        unique case (state)
            S_ACK_ADDR, S_ACK_CMD, S_ACK_CNT, S_ACK_DATA: sda_oe = 1'b1;
            S_PUT_BYTE: sda_oe = ~tx_sh[7];
            S_GET_DATA: wr_en  = scl_fall && byte_full && !stop_det && !start_det
                                 && (wcnt < cnt_lim);
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
    parameter int NREG = 20,
    parameter int RSVD = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl,
    input logic              sda_oe,
    input logic              in_quiet,
    input logic              wr_stb,
    input logic [7:0]        wr_idx,
    input logic [NREG*8-1:0] regs
);
    // R10 / R11: no drive while idle or waiting for the end of a foreign/aborted transfer
    p_quiet_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_quiet |-> !sda_oe);

    // R12: the target starts pulling SDA only during the low phase of SCL
    p_drive_on_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl);

    // R9: strobes only for writable indices
    p_stb_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_idx >= 8'(RSVD) && wr_idx <= 8'(NREG - 3)));

    // R9: strobe lasts exactly one clock
    p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R3 / R5: register contents only move together with a strobe
    p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> (regs == $past(regs)));
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NREG(NREG), .RSVD(RSVD)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda_oe(sda_oe), .in_quiet(in_quiet),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .regs(regs_flat)
);

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;
    localparam int NREG = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_w = 1'b1;
    logic host_sda = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [NREG*8-1:0] regs_flat;
    logic wr_stb;
    logic [7:0] wr_idx, wr_data;

    always #10 clk = ~clk;
    assign sda_bus = host_sda & ~sda_oe;

    i2c_cfg_slave u_i2c_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_w), .sda_in(sda_bus), .sda_oe(sda_oe),
        .regs_flat(regs_flat), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0, clash = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] buf_w [24];
    logic [7:0] buf_r [NREG+1];
    int stb_cnt = 0;
    logic [7:0] stb_idx = 8'h00, stb_dat = 8'h00;

    always @(posedge clk) if (wr_stb) begin
        stb_cnt <= stb_cnt + 1;
        stb_idx <= wr_idx;
        stb_dat <= wr_data;
    end

    function automatic logic [7:0] exp_reset(input int i);
        logic [7:0] t [NREG] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hCE, 8'h00,
                                 8'h08, 8'hAB, 8'h2F, 8'h1F, 8'h4C, 8'hA7, 8'h1C, 8'h24, 8'h77, 8'h11};
        return t[i];
    endfunction

    function automatic bit exp_writable(input int i);
        return (i >= 4 && i <= 17);
    endfunction

    function automatic logic [7:0] exp_read(input int i);
        return (i < NREG) ? model[i] : 8'hFF;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; q(); scl_w = 1'b1; q(); host_sda = 1'b0; q(); scl_w = 1'b0; q();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; q(); scl_w = 1'b1; q(); host_sda = 1'b1; q();
    endtask

    task automatic put_bit(input logic b);
        host_sda = b; q(); scl_w = 1'b1; q();
        if (b && !sda_bus) clash = 1'b1;   // R12 collision with the host
        q(); scl_w = 1'b0; q();
    endtask

    task automatic get_bit(output logic b);
        host_sda = 1'b1; q(); scl_w = 1'b1; q(); b = sda_bus; q(); scl_w = 1'b0; q();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(nack);
    endtask

    task automatic wr_byte_txn(input int idx, input logic [7:0] d);
        logic a0, a1, a2;
        bus_start(); put_byte(8'hD2, a0); put_byte(8'(idx + 1), a1); put_byte(d, a2); bus_stop();
        check8("R1", {5'd0, a0, a1, a2}, 8'h00);
    endtask

    task automatic rd_byte_txn(input int idx, output logic [7:0] d);
        logic a0, a1, a2;
        bus_start(); put_byte(8'hD2, a0); put_byte(8'(idx + 1), a1);
        bus_start(); put_byte(8'hD3, a2); get_byte(1'b1, d); bus_stop();
        check8("R1", {5'd0, a0, a1, a2}, 8'h00);
    endtask

    task automatic blk_wr_txn(input int n, input int nb);
        logic a, acc;
        acc = 1'b0;
        bus_start(); put_byte(8'hD2, a); acc |= a; put_byte(8'h00, a); acc |= a;
        put_byte(8'(n), a); acc |= a;
        for (int i = 0; i < nb; i++) begin put_byte(buf_w[i], a); acc |= a; end
        bus_stop();
        check8("R5", {7'd0, acc}, 8'h00);
    endtask

    task automatic blk_rd_txn(output logic [7:0] cnt);
        logic a0, a1, a2;
        bus_start(); put_byte(8'hD2, a0); put_byte(8'h00, a1);
        bus_start(); put_byte(8'hD3, a2);
        get_byte(1'b0, cnt);
        for (int i = 0; i <= NREG; i++) get_byte(i == NREG, buf_r[i]);
        bus_stop();
        check8("R6", {5'd0, a0, a1, a2}, 8'h00);
    endtask

    task automatic check_block_read();
        logic [7:0] cnt;
        blk_rd_txn(cnt);
        check8("R6", cnt, 8'(NREG));
        for (int i = 0; i < NREG; i++) check8("R6", buf_r[i], model[i]);
        check8("R6", buf_r[NREG], 8'hFF);
    endtask

    task automatic check_ports(input string req);
        for (int i = 0; i < NREG; i++) check8(req, regs_flat[i*8 +: 8], model[i]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        logic a, b0, b1, b2;
        int s0;
        void'($urandom(32'd2024));
        for (int i = 0; i < NREG; i++) model[i] = exp_reset(i);
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R2 / R7 / R8 reset state at the ports
        check_ports("R2");
        check8("R10", {7'd0, sda_oe}, 8'h00);
        check_block_read();                                  // R6 after reset

        // R3 / R9 / R4 single-register write and read-back
        s0 = stb_cnt;
        wr_byte_txn(5, 8'h3C); model[5] = 8'h3C;
        check8("R9", 8'(stb_cnt - s0), 8'd1);
        check8("R9", stb_idx, 8'd5);
        check8("R9", stb_dat, 8'h3C);
        rd_byte_txn(5, d); check8("R4", d, 8'h3C);

        // R8 identification bytes ignore writes, no strobe
        s0 = stb_cnt;
        wr_byte_txn(18, 8'h00); wr_byte_txn(19, 8'hA5);
        check8("R9", 8'(stb_cnt - s0), 8'd0);
        rd_byte_txn(18, d); check8("R8", d, 8'h77);
        rd_byte_txn(19, d); check8("R8", d, 8'h11);

        // R7 placeholder slot
        wr_byte_txn(2, 8'h55);
        rd_byte_txn(2, d); check8("R7", d, 8'h00);
        check8("R7", regs_flat[2*8 +: 8], 8'h00);

        // R4 sequential read continues upward
        bus_start(); put_byte(8'hD2, a); put_byte(8'd15, a);
        bus_start(); put_byte(8'hD3, a); get_byte(1'b0, d); get_byte(1'b1, d2); bus_stop();
        check8("R4", d, model[14]); check8("R4", d2, model[15]);

        // R3 extra bytes after the first are not stored
        bus_start(); put_byte(8'hD2, b0); put_byte(8'd7, b1); put_byte(8'hA1, b2);
        put_byte(8'hB2, a); bus_stop();
        model[6] = 8'hA1;
        check8("R3", {7'd0, a}, 8'h00);
        check8("R3", regs_flat[6*8 +: 8], 8'hA1);
        check8("R3", regs_flat[7*8 +: 8], model[7]);

        // R5 block write with more bytes than the count
        for (int i = 0; i < 8; i++) buf_w[i] = 8'h60 + 8'(i);
        blk_wr_txn(6, 8);
        model[4] = 8'h64; model[5] = 8'h65;
        check_ports("R5");

        // R1 foreign address is ignored
        bus_start(); put_byte(8'hA0, b0); put_byte(8'h05, b1); put_byte(8'hEE, b2); bus_stop();
        check8("R1", {5'd0, b0, b1, b2}, 8'h07);
        check8("R1", regs_flat[4*8 +: 8], model[4]);

        // R10 release after not-acknowledge
        bus_start(); put_byte(8'hD2, a); put_byte(8'd5, a);
        bus_start(); put_byte(8'hD3, a); get_byte(1'b1, d);
        get_bit(b0); get_bit(b1); get_bit(b2); bus_stop();
        check8("R10", {5'd0, b0, b1, b2}, 8'h07);

        // R11 STOP in the middle of an address byte
        bus_start(); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); bus_stop();
        wr_byte_txn(9, 8'h5A); model[9] = 8'h5A;
        rd_byte_txn(9, d); check8("R11", d, 8'h5A);
        // R11 START in the middle of a command byte
        bus_start(); put_byte(8'hD2, a); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_start(); put_byte(8'hD3, a); get_byte(1'b1, d); bus_stop();
        check8("R11", {7'd0, a}, 8'h00);

        // Seeded random mix
        for (int it = 0; it < 24; it++) begin
            int op, k, n, nb;
            op = $urandom_range(2, 0);
            if (op == 0) begin
                k = $urandom_range(21, 0);
                d = 8'($urandom);
                wr_byte_txn(k, d);
                if (exp_writable(k)) model[k] = d;
                rd_byte_txn(k, d2);
                check8("R3", d2, exp_read(k));
            end else if (op == 1) begin
                n  = $urandom_range(22, 0);
                nb = n + $urandom_range(2, 0);
                if (nb > 24) nb = 24;
                for (int i = 0; i < nb; i++) buf_w[i] = 8'($urandom);
                blk_wr_txn(n, nb);
                for (int i = 0; i < n && i < NREG; i++)
                    if (exp_writable(i)) model[i] = buf_w[i];
                check_ports("R5");
            end else begin
                check_block_read();
            end
        end

        check_block_read();
        check_ports("R2");
        check8("R12", {7'd0, clash}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule